// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A word-wide shared memory that sits between two processors, here called side A and side B. Each side has its own synchronous port with byte enables, and the two ports work in the same cycle without stalling each other. Side B treats the memory as its boot store: word 0 is where it fetches its first instruction, so side A loads an image here before B leaves reset.

Two words at the top of the address space act as doorbells. When side A writes the highest word, an interrupt level is raised toward side B. When side B writes the word just below it, an interrupt level is raised toward side A. Each level stays high until the receiving side reads that word. A single semaphore-enable flag, loaded from a small control input, is also kept here and is clear after reset.

With the default `ADDR_W` of 10 the memory holds 1024 words. Setting `ADDR_W` to 15 gives the full 128 KB of 32-bit words.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is held, and after it is released, `a_rdata` and `b_rdata` are zero and `irq_to_a`, `irq_to_b` and `sema_en` are low.
- R2: A port read is a cycle with en=1 and we=0. It returns the word at that address on rdata one cycle later. Rdata keeps its value in every cycle that has no read on that port.
- R3: A write is a cycle with en=1 and we=1. It changes only the byte lanes whose enable bit is set. Lane i is data bits [8i+7:8i], controlled by be[i].
- R4: Both ports can access any addresses in the same cycle. A read on one port of the word that the other port writes in that cycle returns the contents from before the write.
- R5: A write by side A to word address 2^ADDR_W-1 stores its data and raises `irq_to_b` on the next cycle. The level stays high until side B reads that address; after that read it is low on the next cycle.
- R6: A write by side B to word address 2^ADDR_W-2 stores its data and raises `irq_to_a` on the next cycle. The level stays high until side A reads that address; after that read it is low on the next cycle.
- R7: When both ports write the same address in one cycle, side A's write is applied and side B's write is dropped entirely, including any interrupt it would have raised.
- R8: A cycle with `sema_wr`=1 loads `sema_val` into `sema_en`, visible on the next cycle. In all other cycles `sema_en` holds its value.
- R9: When a doorbell word is written by its sender and read by its receiver in the same cycle, the interrupt stays high.
- R10: Side B address 0 is the first memory word, so B reads back the image that A placed from address 0 upward.
- R11: A doorbell is affected by nothing but its sender's write and its receiver's read. A read by the sender does not clear it, and a write by the receiver to that word does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Side A access request |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_be | input | 4 | Side A byte-lane enables |
| a_addr | input | ADDR_W | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one-cycle latency |
| b_en | input | 1 | Side B access request |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_be | input | 4 | Side B byte-lane enables |
| b_addr | input | ADDR_W | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one-cycle latency |
| sema_wr | input | 1 | Load strobe for the semaphore-enable flag |
| sema_val | input | 1 | Value loaded into the flag |
| sema_en | output | 1 | Semaphore-enable flag |
| irq_to_b | output | 1 | Doorbell level toward side B |
| irq_to_a | output | 1 | Doorbell level toward side A |

## Verification
The bench builds the block with `ADDR_W` = 6, a 64-word memory. At that size the two doorbell words, 63 and 62, are hit often by random traffic that also covers every other word. The bench therefore sees many same-cycle collisions, read-during-write cases and set-versus-clear races on the interrupt levels, beyond the directed cases that force each of them.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = WORD_W / LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lanes_t;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } port_op_e;

  function automatic port_op_e decode_op(input logic en, input logic we);
    if (!en)     return OP_IDLE;
    else if (we) return OP_WRITE;
    else         return OP_READ;
  endfunction

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_rd,
  input  logic              a_wr,
  input  lanes_t            a_be,
  input  logic [ADDR_W-1:0] a_addr,
  input  word_t             a_wdata,
  output word_t             a_rdata,
  input  logic              b_rd,
  input  logic              b_wr,
  input  lanes_t            b_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  word_t             b_wdata,
  output word_t             b_rdata,
  output logic              b_wr_eff
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  word_t mem [DEPTH];
  word_t a_rdata_q, a_rdata_d;
  word_t b_rdata_q, b_rdata_d;

  // side A owns the word when both write it in one cycle
  always_comb begin
    b_wr_eff = b_wr && !(a_wr && (a_addr == b_addr));
  end

  // storage: B lanes first, A lanes last so A prevails on any overlap
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (b_wr_eff && b_be[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
      if (a_wr && a_be[l])     mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
    end
  end

  // read next state: sampled before this cycle's writes land
  always_comb begin
    a_rdata_d = a_rd ? mem[a_addr] : a_rdata_q;
    b_rdata_d = b_rd ? mem[b_addr] : b_rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;

  assert_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |=> $stable(a_rdata));
  assert_b_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd |=> $stable(b_rdata));
  assert_b_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && b_wr && (a_addr == b_addr)) |-> !b_wr_eff);
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring,
  input  logic ack,
  output logic pend
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (ack)  pend_d = 1'b0;
    if (ring) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  assert_ring_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ring |=> pend);
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ring) |=> !pend);
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ring && !pend) |=> !pend);
endmodule

// File: rtl/mbox_sema.sv
module mbox_sema (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic val,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = load ? val : flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flag));
  assert_flag_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (flag == $past(val)));
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [3:0]        a_be,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [31:0]       a_wdata,
  output logic [31:0]       a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [3:0]        b_be,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [31:0]       b_wdata,
  output logic [31:0]       b_rdata,
  input  logic              sema_wr,
  input  logic              sema_val,
  output logic              sema_en,
  output logic              irq_to_b,
  output logic              irq_to_a
);
  localparam logic [ADDR_W-1:0] BOX_A2B = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_B2A = BOX_A2B - 1'b1;
  localparam int unsigned       NBELL   = 2;

  logic     rst_n_s;
  port_op_e a_op, b_op;
  logic     a_rd, a_wr, b_rd, b_wr, b_wr_eff;
  logic [NBELL-1:0] ring, ack, pend;

  mbox_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    a_op = decode_op(a_en, a_we);
    b_op = decode_op(b_en, b_we);
    a_rd = (a_op == OP_READ);
    a_wr = (a_op == OP_WRITE);
    b_rd = (b_op == OP_READ);
    b_wr = (b_op == OP_WRITE);
  end

  mbox_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .a_rd     (a_rd),
    .a_wr     (a_wr),
    .a_be     (a_be),
    .a_addr   (a_addr),
    .a_wdata  (a_wdata),
    .a_rdata  (a_rdata),
    .b_rd     (b_rd),
    .b_wr     (b_wr),
    .b_be     (b_be),
    .b_addr   (b_addr),
    .b_wdata  (b_wdata),
    .b_rdata  (b_rdata),
    .b_wr_eff (b_wr_eff)
  );

  // doorbell 0: A rings B; doorbell 1: B rings A
  always_comb begin
    ring[0] = a_wr && (a_addr == BOX_A2B);
    ack[0]  = b_rd && (b_addr == BOX_A2B);
    ring[1] = b_wr_eff && (b_addr == BOX_B2A);
    ack[1]  = a_rd && (a_addr == BOX_B2A);
  end

  for (genvar d = 0; d < NBELL; d++) begin : g_bell
    mbox_doorbell u_bell (
      .clk   (clk),
      .rst_n (rst_n_s),
      .ring  (ring[d]),
      .ack   (ack[d]),
      .pend  (pend[d])
    );
  end

  assign irq_to_b = pend[0];
  assign irq_to_a = pend[1];

  mbox_sema u_sema (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (sema_wr),
    .val   (sema_val),
    .flag  (sema_en)
  );

  assert_irq_b_source_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_to_b && !(a_en && a_we && (a_addr == BOX_A2B))) |=> !irq_to_b);
  assert_irq_a_source_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_to_a && !(b_en && b_we && (b_addr == BOX_B2A))) |=> !irq_to_a);
  assert_irq_a_collide_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!irq_to_a && a_en && a_we && b_en && b_we && (a_addr == b_addr)
     && !(b_addr != BOX_B2A)) |=> !irq_to_a);
endmodule

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int A2B   = DEPTH - 1;
  localparam int B2A   = DEPTH - 2;

  logic clk = 1'b0;
  logic rst_n;
  logic a_en, a_we, b_en, b_we, sema_wr, sema_val;
  logic [3:0] a_be, b_be;
  logic [AW-1:0] a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic sema_en, irq_to_b, irq_to_a;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_dpram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_be(b_be), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .sema_wr(sema_wr), .sema_val(sema_val), .sema_en(sema_en),
    .irq_to_b(irq_to_b), .irq_to_a(irq_to_a)
  );

  // behavioural reference model
  logic [31:0] m [DEPTH];
  bit          kn [DEPTH];
  logic [31:0] ea, eb;
  bit          ea_ok, eb_ok, e_irqb, e_irqa, e_sema;
  int          rel_cnt;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt = 0;
      ea = 0; eb = 0; ea_ok = 1; eb_ok = 1;
      e_irqb = 0; e_irqa = 0; e_sema = 0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      bit awr, bwr, ard, brd, bdrop;
      awr = a_en && a_we; bwr = b_en && b_we;
      ard = a_en && !a_we; brd = b_en && !b_we;
      bdrop = awr && bwr && (a_addr == b_addr);
      if (ard) begin ea = m[a_addr]; ea_ok = kn[a_addr]; end
      if (brd) begin eb = m[b_addr]; eb_ok = kn[b_addr]; end
      if (bwr && !bdrop) begin
        m[b_addr] = merge(m[b_addr], b_wdata, b_be);
        kn[b_addr] = kn[b_addr] && 1'b1 || (b_be == 4'hF);
      end
      if (awr) begin
        m[a_addr] = merge(m[a_addr], a_wdata, a_be);
        kn[a_addr] = kn[a_addr] || (a_be == 4'hF);
      end
      if (awr && a_addr == A2B) e_irqb = 1;
      else if (brd && b_addr == A2B) e_irqb = 0;
      if (bwr && !bdrop && b_addr == B2A) e_irqa = 1;
      else if (ard && a_addr == B2A) e_irqa = 0;
      if (sema_wr) e_sema = sema_val;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      if (ea_ok) chk("R2 a_rdata", a_rdata, ea);
      if (eb_ok) chk("R2 b_rdata", b_rdata, eb);
      chk("R5 irq_to_b", {31'b0, irq_to_b}, {31'b0, e_irqb});
      chk("R6 irq_to_a", {31'b0, irq_to_a}, {31'b0, e_irqa});
      chk("R8 sema_en", {31'b0, sema_en}, {31'b0, e_sema});
    end
  end

  task automatic idle();
    a_en = 0; a_we = 0; a_be = 0; a_addr = 0; a_wdata = 0;
    b_en = 0; b_we = 0; b_be = 0; b_addr = 0; b_wdata = 0;
    sema_wr = 0; sema_val = 0;
  endtask

  task automatic op_a(input bit we, input logic [3:0] be, input int ad, input logic [31:0] d);
    a_en = 1; a_we = we; a_be = be; a_addr = AW'(ad); a_wdata = d;
  endtask

  task automatic op_b(input bit we, input logic [3:0] be, input int ad, input logic [31:0] d);
    b_en = 1; b_we = we; b_be = be; b_addr = AW'(ad); b_wdata = d;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m[i] = 0; kn[i] = 0; end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 a_rdata", a_rdata, 0);
    chk("R1 b_rdata", b_rdata, 0);
    chk("R1 irqs/sema", {29'b0, irq_to_a, irq_to_b, sema_en}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {29'b0, irq_to_a, irq_to_b, sema_en}, 0);

    // R10: boot image fetched by B from word 0
    op_a(1, 4'hF, 0, 32'hDEADBEEF); step();
    op_a(1, 4'hF, 1, 32'h11223344); step();
    op_b(0, 4'h0, 0, 0); step();
    chk("R10 b fetch word0", b_rdata, 32'hDEADBEEF);

    // R3: byte lanes
    op_a(1, 4'b0101, 1, 32'hAABBCCDD); step();
    op_a(0, 4'h0, 1, 0); step();
    chk("R3 lane merge", a_rdata, 32'h11BB33DD);

    // R2: hold when idle
    repeat (3) @(negedge clk);
    chk("R2 a_rdata held", a_rdata, 32'h11BB33DD);

    // R4: read-during-write returns old data
    op_a(1, 4'hF, 2, 32'h01020304); step();
    op_a(1, 4'hF, 2, 32'hCAFEF00D); op_b(0, 4'h0, 2, 0); step();
    chk("R4 old data", b_rdata, 32'h01020304);
    op_b(0, 4'h0, 2, 0); step();
    chk("R4 new data", b_rdata, 32'hCAFEF00D);

    // R7: collision, A wins
    op_a(1, 4'hF, 5, 32'hA5A5A5A5); op_b(1, 4'hF, 5, 32'h5B5B5B5B); step();
    op_a(0, 4'h0, 5, 0); step();
    chk("R7 A wins", a_rdata, 32'hA5A5A5A5);
    op_a(1, 4'hF, B2A, 32'h0000AAAA); op_b(1, 4'hF, B2A, 32'h0000BBBB); step();
    chk("R7 no irq from dropped write", {31'b0, irq_to_a}, 0);

    // R5 / R11 / R9
    op_a(1, 4'hF, A2B, 32'h600DCAFE); step();
    chk("R5 irq_to_b raised", {31'b0, irq_to_b}, 1);
    op_a(0, 4'h0, A2B, 0); step();
    chk("R11 sender read keeps irq", {31'b0, irq_to_b}, 1);
    op_b(1, 4'hF, B2A + 0, 32'h0); step();   // clear R6 side later
    op_a(0, 4'h0, B2A, 0); step();
    op_a(1, 4'hF, A2B, 32'h12345678); op_b(0, 4'h0, A2B, 0); step();
    chk("R9 set beats clear", {31'b0, irq_to_b}, 1);
    chk("R9 old mailbox data", b_rdata, 32'h600DCAFE);
    op_b(0, 4'h0, A2B, 0); step();
    chk("R5 irq_to_b cleared", {31'b0, irq_to_b}, 0);
    chk("R5 mailbox data", b_rdata, 32'h12345678);

    // R6
    op_b(1, 4'hF, B2A, 32'h0BADBEEF); step();
    chk("R6 irq_to_a raised", {31'b0, irq_to_a}, 1);
    op_a(1, 4'hF, B2A + 0, 32'h0BADBEEF); step();
    op_a(0, 4'h0, B2A, 0); step();
    chk("R6 irq_to_a cleared", {31'b0, irq_to_a}, 0);
    chk("R6 mailbox data", a_rdata, 32'h0BADBEEF);
    op_b(1, 4'hF, A2B, 32'h77777777); step();
    chk("R11 receiver write no irq", {31'b0, irq_to_b}, 0);

    // R8
    sema_wr = 1; sema_val = 1; step();
    chk("R8 sema set", {31'b0, sema_en}, 1);
    sema_val = 0; repeat (2) @(negedge clk);
    chk("R8 sema hold", {31'b0, sema_en}, 1);
    sema_wr = 1; sema_val = 0; step();
    chk("R8 sema clear", {31'b0, sema_en}, 0);

    // random traffic compared cycle by cycle (R2 R3 R4 R5 R6 R7 R9)
    for (int n = 0; n < 4000; n++) begin
      int pa, pb;
      pa = ($urandom % 4 == 0) ? (DEPTH - 1 - ($urandom % 2)) : ($urandom % DEPTH);
      pb = ($urandom % 4 == 0) ? (DEPTH - 1 - ($urandom % 2)) : ($urandom % DEPTH);
      if ($urandom % 3 == 0) pb = pa;
      if ($urandom % 4 != 0) op_a($urandom % 2, ($urandom % 2) ? 4'hF : 4'($urandom), pa, $urandom);
      if ($urandom % 4 != 0) op_b($urandom % 2, ($urandom % 2) ? 4'hF : 4'($urandom), pb, $urandom);
      if ($urandom % 16 == 0) begin sema_wr = 1; sema_val = 1'($urandom); end
      step();
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule